// File: doc/BRIEF.md
# Crystal Clock Loss Monitor with Auxiliary Fallback

This block watches an external crystal clock from the domain of a free-running internal reference clock. When monitoring is on and the crystal clock stops toggling, a sticky detection flag is set. At the same moment the block requests that the master clock switch to an auxiliary source, the internal RC oscillator divided by 8, by asserting a fallback-select output. That output drives an external glitch-free clock mux, which is not part of this block.

Software controls the block through one byte-wide control/status register on a simple bus. The bus has an address, a write strobe, write data and combinational read data, and it is clocked by the reference clock. The enable bit can be written only once after reset. The detection flag can only be cleared by writing zero to it. The interrupt output is the detection flag gated by an interrupt-enable bit. The auxiliary-source status bit and the fallback request stay set until the next reset, even if the crystal clock recovers later.

Top module: `clkmon_fallback`

## Requirements
- R1: After reset the register reads 0x00 and `fallback_sel` and `irq` are 0. Bits 7:4 always read as zero.
- R2: Bit 0 (monitor enable) is loaded from write data by the first register write after reset only. Every later write leaves it unchanged.
- R3: Bit 2 (interrupt enable) takes write-data bit 2 on every register write.
- R4: With monitoring on, the flag at bit 3 is set when the monitored clock shows no edge for 16 reference cycles. Measured from the moment the clock stops, it is set no earlier than 14 and no later than 26 reference cycles later. A monitored clock with a period of 12 reference cycles never sets it.
- R5: A register write with bit 3 equal to 0 clears the detection flag. A write with bit 3 equal to 1 leaves it unchanged.
- R6: While monitoring is off, bit 3 reads 0 and a stopped clock sets neither the flag nor `fallback_sel`.
- R7: Bit 1 and `fallback_sel` become 1 together with a detection. They then stay 1 until reset, even when the clock resumes and the flag is cleared. Writes to bit 1 have no effect.
- R8: `irq` is 1 exactly when bit 3 and bit 2 both read 1.
- R9: The register sits at address `CSR_ADDR` (default 0x8). Writes to any other address change nothing, and reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock; also clocks the register bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Crystal clock under supervision |
| addr | input | ADDR_W | Register bus address |
| we | input | 1 | Write strobe, sampled on `ref_clk` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| irq | output | 1 | Detection interrupt |
| fallback_sel | output | 1 | Request to select the auxiliary clock source |

## Verification
A stuck or missed write lock shows as a bit 0 value that changes on a later write, or does not change on the first write. This is visible in the next read. A loss counter that runs too long, never restarts, or never arms shows as a detection flag that rises outside the expected window after the clock stops, or rises while the clock is still toggling slowly. A fallback state that is not sticky appears as `fallback_sel` dropping within one cycle after the flag is cleared. Interrupt gating errors show on `irq` in the same cycle as the matching read.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
   localparam int DATA_W  = 8;
   localparam int BIT_EN  = 0;
   localparam int BIT_AUX = 1;
   localparam int BIT_IE  = 2;
   localparam int BIT_DET = 3;
   typedef logic [DATA_W-1:0] csr_byte_t;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("clkmon_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[0], d};
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmon_loss_det.sv
module clkmon_loss_det #(
   parameter int TIMEOUT     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic mon_clk,
   input  logic arm,
   output logic loss_evt
);
   localparam int CNT_W = $clog2(TIMEOUT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);
   localparam logic [CNT_W-1:0] SAT  = CNT_W'(TIMEOUT);

   generate
      if (TIMEOUT < 4) begin : g_bad_to
         $error("clkmon_loss_det: TIMEOUT must be at least 4");
      end
   endgenerate

   logic             tgl;
   logic             tgl_s;
   logic             tgl_d;
   logic             seen_edge;
   logic [CNT_W-1:0] quiet_cnt;

   always_ff @(posedge mon_clk or negedge rst_n) begin
      if (!rst_n) tgl <= 1'b0;
      else        tgl <= ~tgl;
   end

   clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (tgl),
      .q     (tgl_s)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) tgl_d <= 1'b0;
      else        tgl_d <= tgl_s;
   end

   assign seen_edge = tgl_s ^ tgl_d;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)                 quiet_cnt <= '0;
      else if (!arm || seen_edge) quiet_cnt <= '0;
      else if (quiet_cnt != SAT)  quiet_cnt <= quiet_cnt + 1'b1;
   end

   assign loss_evt = arm && !seen_edge && (quiet_cnt == LAST);
endmodule

// File: rtl/clkmon_csr.sv
module clkmon_csr
   import clkmon_pkg::*;
#(
   parameter int                ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] CSR_ADDR = 4'h8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  csr_byte_t         wdata,
   input  logic              loss_evt,
   output csr_byte_t         rdata,
   output logic              mon_en,
   output logic              det_flag,
   output logic              wr_lock,
   output logic              irq,
   output logic              fallback_sel
);
   logic hit;
   logic ie_q;
   logic aux_q;
   logic unused_wbits;

   assign hit          = we && (addr == CSR_ADDR);
   assign unused_wbits = ^{wdata[DATA_W-1:4], wdata[BIT_AUX]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_lock  <= 1'b0;
         mon_en   <= 1'b0;
         ie_q     <= 1'b0;
         det_flag <= 1'b0;
         aux_q    <= 1'b0;
      end else begin
         if (hit) begin
            ie_q <= wdata[BIT_IE];
            if (!wr_lock) begin
               mon_en  <= wdata[BIT_EN];
               wr_lock <= 1'b1;
            end
         end
         if (loss_evt && mon_en) begin
            det_flag <= 1'b1;
            aux_q    <= 1'b1;
         end else if (hit && !wdata[BIT_DET]) begin
            det_flag <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == CSR_ADDR) begin
         rdata[BIT_EN]  = mon_en;
         rdata[BIT_AUX] = aux_q;
         rdata[BIT_IE]  = ie_q;
         rdata[BIT_DET] = det_flag && mon_en;
      end
   end

   assign irq          = det_flag && mon_en && ie_q;
   assign fallback_sel = aux_q;
endmodule

// File: rtl/clkmon_fallback.sv
module clkmon_fallback
   import clkmon_pkg::*;
#(
   parameter int                ADDR_W      = 4,
   parameter logic [ADDR_W-1:0] CSR_ADDR    = 4'h8,
   parameter int                TIMEOUT     = 16,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              mon_clk,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq,
   output logic              fallback_sel
);
   generate
      if (ADDR_W < 1) begin : g_bad_aw
         $error("clkmon_fallback: ADDR_W must be positive");
      end
   endgenerate

   logic mon_en;
   logic det_flag;
   logic wr_lock;
   logic loss_evt;

   clkmon_loss_det #(
      .TIMEOUT     (TIMEOUT),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_loss (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .mon_clk  (mon_clk),
      .arm      (mon_en),
      .loss_evt (loss_evt)
   );

   clkmon_csr #(
      .ADDR_W   (ADDR_W),
      .CSR_ADDR (CSR_ADDR)
   ) u_csr (
      .clk          (ref_clk),
      .rst_n        (rst_n),
      .addr         (addr),
      .we           (we),
      .wdata        (wdata),
      .loss_evt     (loss_evt),
      .rdata        (rdata),
      .mon_en       (mon_en),
      .det_flag     (det_flag),
      .wr_lock      (wr_lock),
      .irq          (irq),
      .fallback_sel (fallback_sel)
   );
endmodule

// File: rtl/clkmon_fallback_chk.sv
module clkmon_fallback_chk #(
   parameter int                ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] CSR_ADDR = 4'h8
) (
   input logic              ref_clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              we,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic              irq,
   input logic              fallback_sel,
   input logic              mon_en,
   input logic              det_flag,
   input logic              wr_lock
);
   AST_RSVD_ZERO: assert property (@(posedge ref_clk) disable iff (!rst_n)
      rdata[7:4] == 4'h0); // R1
   AST_EN_LOCKED: assert property (@(posedge ref_clk) disable iff (!rst_n)
      wr_lock |=> $stable(mon_en)); // R2
   AST_DET_KEEP_ON_ONE: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (det_flag && we && addr == CSR_ADDR && wdata[3]) |=> det_flag); // R5
   AST_DET_NEEDS_EN: assert property (@(posedge ref_clk) disable iff (!rst_n)
      det_flag |-> mon_en); // R6
   AST_FALLBACK_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
      fallback_sel |=> fallback_sel); // R7
   AST_FALLBACK_WITH_DET: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(det_flag) |-> fallback_sel); // R7
   AST_IRQ_VIEW: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (addr == CSR_ADDR) |-> (irq == (rdata[3] && rdata[2]))); // R8
   AST_OTHER_ADDR_ZERO: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (addr != CSR_ADDR) |-> (rdata == 8'h00)); // R9
endmodule

bind clkmon_fallback clkmon_fallback_chk #(
   .ADDR_W   (ADDR_W),
   .CSR_ADDR (CSR_ADDR)
) u_chk (
   .ref_clk      (ref_clk),
   .rst_n        (rst_n),
   .addr         (addr),
   .we           (we),
   .wdata        (wdata),
   .rdata        (rdata),
   .irq          (irq),
   .fallback_sel (fallback_sel),
   .mon_en       (mon_en),
   .det_flag     (det_flag),
   .wr_lock      (wr_lock)
);

// File: tb/test_clkmon_fallback.sv
`timescale 1ns/1ps
module test_clkmon_fallback;
   localparam logic [3:0] CSR = 4'h8;

   logic       ref_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic       mon_clk = 1'b0;
   logic [3:0] addr    = CSR;
   logic       we      = 1'b0;
   logic [7:0] wdata   = 8'h00;
   logic [7:0] rdata;
   logic       irq;
   logic       fallback_sel;

   int  errors = 0;
   int  checks = 0;
   bit  mon_run = 1'b1;
   int  mon_half = 5;
   bit  done = 1'b0;

   bit  m_en, m_ie, m_det, m_aux, m_lock;

   clkmon_fallback i_clkmon_fallback (
      .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .addr(addr),
      .we(we), .wdata(wdata), .rdata(rdata), .irq(irq), .fallback_sel(fallback_sel)
   );

   always #2 ref_clk = ~ref_clk;

   initial forever begin
      #(mon_half);
      if (mon_run) mon_clk = ~mon_clk;
   end

   function automatic logic [7:0] exp_byte();
      return {4'h0, m_det & m_en, m_ie, m_aux, m_en};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge ref_clk);
      rst_n = 1'b0; we = 1'b0; addr = CSR;
      repeat (3) @(negedge ref_clk);
      rst_n = 1'b1;
      m_en = 0; m_ie = 0; m_det = 0; m_aux = 0; m_lock = 0;
      @(negedge ref_clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge ref_clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge ref_clk);
      we = 1'b0; addr = CSR;
      if (a == CSR) begin
         m_ie = d[2];
         if (!m_lock) begin m_en = d[0]; m_lock = 1; end
         if (!d[3]) m_det = 0;
      end
   endtask

   task automatic rd_chk(input string req);
      addr = CSR; #0.5;
      chk(rdata == exp_byte(), req, rdata, exp_byte());
      chk(irq == (m_det & m_en & m_ie), {req, " irq"}, irq, m_det & m_en & m_ie);
      chk(fallback_sel == m_aux, {req, " fallback"}, fallback_sel, m_aux);
   endtask

   task automatic stop_and_measure(input string req);
      int n = -1;
      @(negedge ref_clk);
      mon_run = 1'b0;
      for (int i = 1; i <= 40; i++) begin
         @(negedge ref_clk); #0.5;
         if (n < 0 && rdata[3]) n = i;
      end
      chk(n >= 14 && n <= 26, {req, " detect delay"}, n, 20);
      m_det = 1; m_aux = 1;
   endtask

   initial begin
      #800000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      do_reset();
      rd_chk("R1 reset");

      // first write with enable=0 locks monitoring off (R2, R6)
      wr(CSR, 8'h04); rd_chk("R2 first write");
      wr(CSR, 8'h01); rd_chk("R2 enable locked off");
      wr(CSR, 8'h05); rd_chk("R3 ie set");
      @(negedge ref_clk); mon_run = 1'b0;
      repeat (40) @(negedge ref_clk);
      rd_chk("R6 no detect while off");
      mon_run = 1'b1;
      repeat (5) @(negedge ref_clk);

      do_reset();
      wr(CSR, 8'h01); rd_chk("R2 enable on");
      wr(CSR, 8'h00); rd_chk("R2 enable kept");
      wr(CSR, 8'hF0); rd_chk("R1 reserved read zero");

      // random traffic while clock runs (R3, R9)
      for (int i = 0; i < 80; i++) begin
         logic [3:0] a;
         logic [7:0] d;
         a = ($urandom % 3 == 0) ? 4'($urandom) : CSR;
         d = 8'($urandom);
         wr(a, d);
         rd_chk(a == CSR ? "R3 random write" : "R9 foreign write");
         addr = 4'($urandom); #0.5;
         if (addr != CSR) chk(rdata == 8'h00, "R9 foreign read", rdata, 0);
         addr = CSR;
      end

      // slow but alive clock: period 12 reference cycles (R4)
      mon_half = 24;
      repeat (150) @(negedge ref_clk);
      rd_chk("R4 slow clock no detect");
      mon_half = 5;
      repeat (10) @(negedge ref_clk);

      wr(CSR, 8'h01);
      stop_and_measure("R4");
      rd_chk("R7 fallback on detect");
      wr(CSR, 8'h0D); rd_chk("R5 write one keeps flag");
      chk(irq == 1'b1, "R8 irq asserted", irq, 1);
      @(negedge ref_clk); mon_run = 1'b1;
      repeat (20) @(negedge ref_clk);
      wr(CSR, 8'h06); rd_chk("R5 write zero clears flag");
      chk(irq == 1'b0, "R8 irq cleared", irq, 0);
      repeat (50) @(negedge ref_clk);
      rd_chk("R7 fallback sticky after recovery");
      wr(CSR, 8'h00); rd_chk("R7 aux bit not writable");

      stop_and_measure("R4 second loss");
      rd_chk("R8 no irq when ie off");

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule